// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the host-facing register and interrupt core of a two-channel serial controller. A byte-wide synchronous bus with single-cycle read and write strobes reaches four ports: a control port and a data port for each of channel A and channel B. Most registers are reached indirectly. A control write selects a register index, and the next control access, a read or a write, uses that index. After that access the index returns to zero.

Each channel keeps its own write register bank, a receive holding byte, receive and transmit pending flags, and receive and transmit under-service flags. The channels share two registers. One is an interrupt vector that is rewritten on every interrupt event and is read through channel B. The other is a pending-summary register that is read through channel A. A receive interrupt under service blocks a transmit interrupt from being recorded as under service. Clearing the receive interrupt brings the transmit interrupt back.

Received bytes enter on a valid/data pair for each channel, and break conditions enter on a pulse for each channel. A data-port write emits the byte on a one-cycle transmit strobe. The single interrupt output is the OR of both channels' requests and is registered.

Top module: `dual_serial_regif`

## Requirements
- R1: Address bit 0 selects the port (0 = control, 1 = data) and address bit 1 selects the channel (0 = B, 1 = A). Registers of one channel are not visible through the other channel.
- R2: A control write made while the index is 0 loads the index from data bits 2:0. If data bits 5:3 are 001, 8 is added to the index. Read index 12 and read index 13 return the values last written to write index 12 and write index 13.
- R3: A control read, or a control write made while the index is nonzero, accesses the indexed register. The index is then 0 again, so the next control read returns status register 0.
- R4: After reset, status 0 reads 0x44, status 1 reads 0x07, the vector (read index 2 on channel B) reads 0x00 and the interrupt output is low.
- R5: A received byte is taken only while write index 3 bit 0 is set and status 0 bit 0 (byte available) is clear. Taking a byte sets status 0 bit 0. A byte offered under any other condition is dropped.
- R6: A data-port read returns the held byte, clears status 0 bit 0 and clears the channel's receive interrupt.
- R7: A channel requests an interrupt when write index 1 bit 1 is set and a transmit interrupt is pending. It also requests one when write index 1 bits 4:3 are 01 or 10 and a receive interrupt is pending. It also requests one when write index 15 bit 7 and status 0 bit 7 are both set. The output is the registered OR of both channels' requests.
- R8: The vector takes these values. Receive A gives 0x0C (0x30), receive B gives 0x04 (0x20), transmit A gives 0x08 (0x10), transmit B gives 0x00, and no interrupt gives 0x06 (0x60). The value in parentheses is used when the originating channel's write index 9 bit 4 is set. The summary register (read index 3 on channel A) has these bits: receive A 0x20, transmit A 0x10, receive B 0x04, transmit B 0x02.
- R9: A transmit interrupt raised while a receive interrupt is under service stays pending and changes neither the vector nor the summary register. Clearing the receive interrupt then records the transmit interrupt.
- R10: Command 0x28, written while the index is 0, clears the pending transmit interrupt. Command 0x38 clears receive-under-service and re-raises a pending transmit interrupt. If no receive interrupt is under service, 0x38 clears transmit-under-service instead.
- R11: A write to index 9 with data bits 7:6 set to 01 resets channel B, 10 resets channel A and 11 resets both, from either channel's port. Such a write is not stored. A write with bits 7:6 set to 00 is stored.
- R12: A break pulse sets status 0 bit 7. The bit stays set until its channel is reset.
- R13: A data-port write emits the byte with a one-cycle transmit strobe on the following edge, but only if that channel's write index 5 bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 2 | Bit 0 selects control/data, bit 1 selects channel B/A |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Single-cycle read strobe (ignored during a write) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data of the addressed port |
| rx_valid_i | input | 2 | Received-byte valid, index 0 = B, 1 = A |
| rx_data_b_i | input | 8 | Received byte for channel B |
| rx_data_a_i | input | 8 | Received byte for channel A |
| brk_i | input | 2 | Break-detected pulse, index 0 = B, 1 = A |
| tx_valid_o | output | 2 | Transmit strobe, index 0 = B, 1 = A |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Several properties are checked on every cycle. The index must be zero after each access that ends it. The held byte must stay stable while status 0 bit 0 is set. Break status must persist until a reset write. The vector must always hold one of its legal codes. A transmit strobe must follow a data write. The interrupt output must stay low while every enable is off. Other behaviour depends on the order of events, so only the bench scenarios can show it. This covers the hold-off and re-raise of a transmit interrupt behind a receive under service, the exact vector and summary codes in both status forms, the effect of the two commands, and which channel each reset code clears.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  parameter int DW   = 8;
  parameter int NREG = 16;
  localparam int PW  = $clog2(NREG);

  localparam logic CH_B = 1'b0;
  localparam logic CH_A = 1'b1;

  localparam int IX_IEN = 1;
  localparam int IX_RXC = 3;
  localparam int IX_FMT = 4;
  localparam int IX_TXC = 5;
  localparam int IX_MIC = 9;
  localparam int IX_CLK = 11;
  localparam int IX_BRL = 12;
  localparam int IX_BRH = 13;
  localparam int IX_MSC = 14;
  localparam int IX_XIE = 15;

  typedef struct packed {
    logic [NREG-1:0][DW-1:0] wr;
    logic [DW-1:0] rr0;
    logic [DW-1:0] rr1;
    logic [DW-1:0] rxb;
    logic [PW-1:0] ptr;
    logic          rxint;
    logic          txint;
    logic          rx_us;
    logic          tx_us;
  } chn_t;

  typedef struct packed {
    chn_t [1:0]    ch;
    logic [DW-1:0] vec;
    logic [DW-1:0] ipend;
  } core_t;

  function automatic core_t f_vec_idle(core_t s, logic c);
    s.vec = s.ch[c].wr[IX_MIC][4] ? 8'h60 : 8'h06;
    return s;
  endfunction

  function automatic core_t f_set_rx(core_t s, logic c);
    logic hi;
    hi = s.ch[c].wr[IX_MIC][4];
    s.ch[c].rxint = 1'b1;
    s.ch[c].rx_us = 1'b1;
    if (c == CH_A) begin
      s.ipend = s.ipend | 8'h20;
      s.vec   = hi ? 8'h30 : 8'h0C;
    end else begin
      s.ipend = s.ipend | 8'h04;
      s.vec   = hi ? 8'h20 : 8'h04;
    end
    return s;
  endfunction

  function automatic core_t f_set_tx(core_t s, logic c);
    logic hi;
    hi = s.ch[c].wr[IX_MIC][4];
    s.ch[c].txint = 1'b1;
    if (!s.ch[c].rx_us) begin
      s.ch[c].tx_us = 1'b1;
      if (c == CH_A) begin
        if (s.ch[c].wr[IX_IEN][1]) s.ipend = s.ipend | 8'h10;
        s.vec = hi ? 8'h10 : 8'h08;
      end else begin
        if (s.ch[c].wr[IX_IEN][1]) s.ipend = s.ipend | 8'h02;
        s.vec = 8'h00;
      end
    end
    return s;
  endfunction

  function automatic core_t f_clr_rx(core_t s, logic c);
    s.ch[c].rxint = 1'b0;
    s.ch[c].rx_us = 1'b0;
    s = f_vec_idle(s, c);
    s.ipend = s.ipend & ((c == CH_A) ? 8'hDF : 8'hFB);
    if (s.ch[c].txint) s = f_set_tx(s, c);
    return s;
  endfunction

  function automatic core_t f_clr_tx(core_t s, logic c);
    s.ch[c].txint = 1'b0;
    s.ch[c].tx_us = 1'b0;
    s = f_vec_idle(s, c);
    s.ipend = s.ipend & ((c == CH_A) ? 8'hEF : 8'hFD);
    if (s.ch[c].rxint) s = f_set_rx(s, c);
    return s;
  endfunction

  function automatic core_t f_chan_reset(core_t s, logic c);
    s.ch[c] = '0;
    s.ch[c].wr[IX_FMT] = 8'h04;
    s.ch[c].wr[IX_MIC] = 8'hC0;
    s.ch[c].wr[IX_CLK] = 8'h08;
    s.ch[c].wr[IX_MSC] = 8'h30;
    s.ch[c].wr[IX_XIE] = 8'hF8;
    s.ch[c].rr0 = 8'h44;
    s.ch[c].rr1 = 8'h07;
    if (c == CH_B) s.vec = '0;
    else           s.ipend = '0;
    return s;
  endfunction

  function automatic core_t f_reset_all();
    core_t s;
    s = '0;
    s = f_chan_reset(s, CH_B);
    s = f_chan_reset(s, CH_A);
    return s;
  endfunction

  function automatic logic [DW-1:0] f_rr_read(core_t s, logic c, logic [PW-1:0] idx);
    logic [DW-1:0] v;
    case (idx)
      4'd0:    v = s.ch[c].rr0;
      4'd1:    v = s.ch[c].rr1;
      4'd2:    v = (c == CH_B) ? s.vec : '0;
      4'd3:    v = (c == CH_A) ? s.ipend : '0;
      4'd12:   v = s.ch[c].wr[IX_BRL];
      4'd13:   v = s.ch[c].wr[IX_BRH];
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/dsr_decode.sv
module dsr_decode (
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  output logic       wr_en_o,
  output logic       rd_en_o,
  output logic       is_data_o,
  output logic       chan_o
);
  assign is_data_o = addr_i[0];
  assign chan_o    = addr_i[1];
  assign wr_en_o   = wr_i;
  assign rd_en_o   = rd_i && !wr_i;
endmodule

// File: rtl/dsr_irq.sv
module dsr_irq
  import dsr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0][DW-1:0]  ien_i,
  input  logic [1:0]          brk_en_i,
  input  logic [1:0]          brk_st_i,
  input  logic [1:0]          txp_i,
  input  logic [1:0]          rxp_i,
  output logic                irq_o
);
  logic [1:0] req;

  for (genvar c = 0; c < 2; c++) begin : g_req
    logic rx_mode_on;
    assign rx_mode_on = (ien_i[c][4:3] == 2'b01) || (ien_i[c][4:3] == 2'b10);
    assign req[c] = (ien_i[c][1] && txp_i[c]) ||
                    (rx_mode_on && rxp_i[c]) ||
                    (brk_en_i[c] && brk_st_i[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |req;
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ien_i[0][1] == 1'b0 && ien_i[1][1] == 1'b0 && ien_i[0][4:3] == 2'b00 &&
     ien_i[1][4:3] == 2'b00 && brk_en_i == 2'b00) |=> !irq_o)
    else $error("irq raised with every enable off"); // R7
endmodule

// File: rtl/dsr_core.sv
module dsr_core
  import dsr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic                is_data_i,
  input  logic                chan_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [1:0]          rx_valid_i,
  input  logic [1:0][DW-1:0]  rx_data_i,
  input  logic [1:0]          brk_i,
  output logic [DW-1:0]       rdata_o,
  output logic [1:0]          tx_valid_o,
  output logic [DW-1:0]       tx_data_o,
  output core_t               st_o
);
  core_t q, d;
  logic [2:0] cmd;
  assign cmd = wdata_i[5:3];

  always_comb begin
    d = q;
    if (wr_en_i) begin
      if (is_data_i) begin
        d.ch[chan_i].rr0[2] = 1'b1;
        d.ch[chan_i].rr1[0] = 1'b1;
        d = f_set_tx(d, chan_i);
      end else if (q.ch[chan_i].ptr == '0) begin
        d.ch[chan_i].ptr = {(cmd == 3'b001), wdata_i[2:0]};
        if (cmd == 3'b101) begin
          d = f_clr_tx(d, chan_i);
        end else if (cmd == 3'b111) begin
          if (d.ch[chan_i].rx_us) begin
            d.ch[chan_i].rx_us = 1'b0;
            if (d.ch[chan_i].txint) d = f_set_tx(d, chan_i);
          end else begin
            d.ch[chan_i].tx_us = 1'b0;
          end
        end
      end else begin
        d.ch[chan_i].ptr = '0;
        if (q.ch[chan_i].ptr == PW'(IX_MIC)) begin
          case (wdata_i[7:6])
            2'b01:   d = f_chan_reset(d, CH_B);
            2'b10:   d = f_chan_reset(d, CH_A);
            2'b11:   d = f_reset_all();
            default: d.ch[chan_i].wr[IX_MIC] = wdata_i;
          endcase
        end else begin
          d.ch[chan_i].wr[q.ch[chan_i].ptr] = wdata_i;
        end
      end
    end else if (rd_en_i) begin
      if (is_data_i) begin
        d.ch[chan_i].rr0[0] = 1'b0;
        d = f_clr_rx(d, chan_i);
      end else begin
        d.ch[chan_i].ptr = '0;
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (rx_valid_i[c] && d.ch[c].wr[IX_RXC][0] && !d.ch[c].rr0[0]) begin
        d.ch[c].rr0[0] = 1'b1;
        d.ch[c].rxb    = rx_data_i[c];
        d = f_set_rx(d, 1'(c));
      end
      if (brk_i[c]) d.ch[c].rr0[7] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= f_reset_all();
    else     q <= d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid_o <= '0;
      tx_data_o  <= '0;
    end else begin
      for (int c = 0; c < 2; c++)
        tx_valid_o[c] <= wr_en_i && is_data_i && (chan_i == 1'(c)) &&
                         q.ch[c].wr[IX_TXC][3];
      if (wr_en_i && is_data_i) tx_data_o <= wdata_i;
    end
  end

  assign rdata_o = is_data_i ? q.ch[chan_i].rxb : f_rr_read(q, chan_i, q.ch[chan_i].ptr);
  assign st_o    = q;

  for (genvar c = 0; c < 2; c++) begin : g_chk
    AST_PTR_RETURN: assert property (@(posedge clk) disable iff (rst)
      (((wr_en_i && q.ch[c].ptr != '0) || rd_en_i) && !is_data_i && chan_i == 1'(c))
      |=> (q.ch[c].ptr == '0))
      else $error("index not back to zero"); // R3
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
      (q.ch[c].rr0[0] && !wr_en_i && !(rd_en_i && is_data_i && chan_i == 1'(c)))
      |=> $stable(q.ch[c].rxb))
      else $error("held byte overwritten"); // R5
    AST_BRK_STICKY: assert property (@(posedge clk) disable iff (rst)
      (q.ch[c].rr0[7] && !wr_en_i) |=> q.ch[c].rr0[7])
      else $error("break status lost"); // R12
    AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
      tx_valid_o[c] |-> $past(wr_en_i && is_data_i && chan_i == 1'(c)))
      else $error("transmit strobe without data write"); // R13
  end

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    q.vec inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60})
    else $error("illegal vector code"); // R8
endmodule

// File: rtl/dual_serial_regif.sv
module dual_serial_regif
  import dsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_addr_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [1:0]    rx_valid_i,
  input  logic [DW-1:0] rx_data_b_i,
  input  logic [DW-1:0] rx_data_a_i,
  input  logic [1:0]    brk_i,
  output logic [1:0]    tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          irq_o
);
  logic wr_en, rd_en, is_data, chan;
  core_t st;
  logic [1:0][DW-1:0] ien;
  logic [1:0] brk_en, brk_st, txp, rxp;

  dsr_decode u_decode (
    .addr_i   (bus_addr_i),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .wr_en_o  (wr_en),
    .rd_en_o  (rd_en),
    .is_data_o(is_data),
    .chan_o   (chan)
  );

  dsr_core u_core (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .is_data_i (is_data),
    .chan_i    (chan),
    .wdata_i   (bus_wdata_i),
    .rx_valid_i(rx_valid_i),
    .rx_data_i ({rx_data_a_i, rx_data_b_i}),
    .brk_i     (brk_i),
    .rdata_o   (bus_rdata_o),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o),
    .st_o      (st)
  );

  for (genvar c = 0; c < 2; c++) begin : g_tap
    assign ien[c]    = st.ch[c].wr[IX_IEN];
    assign brk_en[c] = st.ch[c].wr[IX_XIE][7];
    assign brk_st[c] = st.ch[c].rr0[7];
    assign txp[c]    = st.ch[c].txint;
    assign rxp[c]    = st.ch[c].rxint;
  end

  dsr_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .ien_i   (ien),
    .brk_en_i(brk_en),
    .brk_st_i(brk_st),
    .txp_i   (txp),
    .rxp_i   (rxp),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/dual_serial_regif_bench.sv
module dual_serial_regif_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] rx_valid = '0;
  logic [7:0] rx_b = '0, rx_a = '0;
  logic [1:0] brk = '0;
  logic [1:0] tx_valid;
  logic [7:0] tx_data;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_serial_regif u_dual_serial_regif (
    .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rx_valid_i(rx_valid),
    .rx_data_b_i(rx_b), .rx_data_a_i(rx_a), .brk_i(brk),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .irq_o(irq)
  );

  // {is_read, addr, wdata, expected}
  localparam logic [18:0] VEC [0:15] = '{
    {1'b0, 2'd0, 8'h0C, 8'h00},
    {1'b0, 2'd0, 8'h5A, 8'h00},
    {1'b0, 2'd0, 8'h0C, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h5A},   // R2 point-high readback
    {1'b1, 2'd0, 8'h00, 8'h44},   // R3 index back at zero
    {1'b0, 2'd0, 8'h01, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h07},   // R2 low index
    {1'b0, 2'd2, 8'h0D, 8'h00},
    {1'b0, 2'd2, 8'hA5, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h44},   // R3 after write at nonzero index
    {1'b0, 2'd2, 8'h0D, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'hA5},   // R1 channel A bank
    {1'b0, 2'd0, 8'h0D, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h00},   // R1 channel B untouched
    {1'b0, 2'd0, 8'h0C, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h5A}    // R1 channel B kept its own
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] dv);
    @(negedge clk); addr = a; wdata = dv; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] dv);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 dv = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic setreg(input logic ch, input logic [3:0] idx, input logic [7:0] v);
    bwr({ch, 1'b0}, idx[3] ? {5'b00001, idx[2:0]} : {4'h0, idx});
    bwr({ch, 1'b0}, v);
  endtask

  task automatic getreg(input logic ch, input logic [3:0] idx, output logic [7:0] v);
    bwr({ch, 1'b0}, idx[3] ? {5'b00001, idx[2:0]} : {4'h0, idx});
    brd({ch, 1'b0}, v);
  endtask

  task automatic rxin(input logic ch, input logic [7:0] dv);
    @(negedge clk);
    if (ch) rx_a = dv; else rx_b = dv;
    rx_valid[ch] = 1'b1;
    @(negedge clk); rx_valid = '0;
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {7'b0, irq}, {7'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R4 reset state
    check("R4 irq", {7'b0, irq}, 8'h00);
    getreg(1'b0, 4'd0, v); check("R4 status0", v, 8'h44);
    getreg(1'b1, 4'd1, v); check("R4 status1", v, 8'h07);
    getreg(1'b0, 4'd2, v); check("R4 vector", v, 8'h00);

    // R1 R2 R3 vector walk
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][18]) begin
        brd(VEC[i][17:16], v);
        check($sformatf("R1/R2/R3 step %0d", i), v, VEC[i][7:0]);
      end else begin
        bwr(VEC[i][17:16], VEC[i][15:8]);
      end
    end

    // R5 R6 R7 R8 receive on B
    setreg(1'b0, 4'd3, 8'h01);
    setreg(1'b0, 4'd1, 8'h10);
    rxin(1'b0, 8'h3C);
    chk_irq("R7 rx irq", 1'b1);
    getreg(1'b0, 4'd0, v); check("R5 available", v, 8'h45);
    getreg(1'b0, 4'd2, v); check("R8 vec rx B", v, 8'h04);
    getreg(1'b1, 4'd3, v); check("R8 summary rx B", v, 8'h04);
    rxin(1'b0, 8'h99);
    brd(2'd1, v); check("R6 data/R5 drop", v, 8'h3C);
    getreg(1'b0, 4'd0, v); check("R6 cleared", v, 8'h44);
    getreg(1'b0, 4'd2, v); check("R8 vec idle", v, 8'h06);
    chk_irq("R6 irq low", 1'b0);
    rxin(1'b1, 8'h55);
    getreg(1'b1, 4'd0, v); check("R5 rx disabled", v, 8'h44);

    // R9 transmit held off behind receive
    setreg(1'b1, 4'd1, 8'h12);
    setreg(1'b1, 4'd3, 8'h01);
    rxin(1'b1, 8'hC3);
    getreg(1'b0, 4'd2, v); check("R8 vec rx A", v, 8'h0C);
    bwr(2'd3, 8'h41);
    getreg(1'b0, 4'd2, v); check("R9 vec held", v, 8'h0C);
    getreg(1'b1, 4'd3, v); check("R9 summary held", v, 8'h20);
    brd(2'd3, v); check("R6 data A", v, 8'hC3);
    getreg(1'b0, 4'd2, v); check("R9 vec tx A", v, 8'h08);
    getreg(1'b1, 4'd3, v); check("R9 summary tx A", v, 8'h10);
    chk_irq("R9 irq tx", 1'b1);
    bwr(2'd2, 8'h28);
    getreg(1'b0, 4'd2, v); check("R10 clr tx vec", v, 8'h06);
    chk_irq("R10 clr tx irq", 1'b0);

    // R10 end of service
    rxin(1'b1, 8'h11);
    bwr(2'd3, 8'h22);
    bwr(2'd2, 8'h38);
    getreg(1'b0, 4'd2, v); check("R10 ius vec", v, 8'h08);
    getreg(1'b1, 4'd3, v); check("R10 ius summary", v, 8'h30);
    brd(2'd3, v);
    bwr(2'd2, 8'h28);
    chk_irq("R10 cleanup irq", 1'b0);

    // R8 status-high form
    setreg(1'b0, 4'd9, 8'h10);
    rxin(1'b0, 8'h7E);
    getreg(1'b0, 4'd2, v); check("R8 hi rx B", v, 8'h20);
    brd(2'd1, v);
    getreg(1'b0, 4'd2, v); check("R8 hi idle", v, 8'h60);

    // R12 break, R11 reset B
    @(negedge clk); brk = 2'b01; @(negedge clk); brk = '0;
    getreg(1'b0, 4'd0, v); check("R12 break set", v, 8'hC4);
    chk_irq("R7 break irq", 1'b1);
    getreg(1'b0, 4'd0, v); check("R12 break sticky", v, 8'hC4);
    setreg(1'b0, 4'd9, 8'h40);
    getreg(1'b0, 4'd0, v); check("R11 reset B status", v, 8'h44);
    getreg(1'b0, 4'd12, v); check("R11 reset B reg", v, 8'h00);
    chk_irq("R11 irq low", 1'b0);

    // R11 reset A from B port, then both
    setreg(1'b1, 4'd12, 8'h11);
    setreg(1'b0, 4'd12, 8'h22);
    setreg(1'b0, 4'd9, 8'h80);
    getreg(1'b1, 4'd12, v); check("R11 reset A", v, 8'h00);
    getreg(1'b0, 4'd12, v); check("R11 B kept", v, 8'h22);
    setreg(1'b1, 4'd9, 8'hC0);
    getreg(1'b0, 4'd12, v); check("R11 reset both", v, 8'h00);

    // R13 transmit strobe
    setreg(1'b0, 4'd5, 8'h08);
    @(negedge clk); addr = 2'd1; wdata = 8'h77; wr = 1'b1;
    @(posedge clk); #1;
    check("R13 strobe B", {6'b0, tx_valid}, 8'h01);
    check("R13 byte", tx_data, 8'h77);
    @(negedge clk); wr = 1'b0;
    @(posedge clk); #1;
    check("R13 one cycle", {6'b0, tx_valid}, 8'h00);
    @(negedge clk); addr = 2'd3; wdata = 8'h66; wr = 1'b1;
    @(posedge clk); #1;
    check("R13 disabled A", {6'b0, tx_valid}, 8'h00);
    @(negedge clk); wr = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule